// File: doc/BRIEF.md
# Bandwidth-Driven Pressure Regulator

This block sits next to a single initiator on an on-chip interconnect and drives the 2-bit urgency (pressure) level that the initiator presents to the interconnect arbiter. It measures the bytes the initiator moves and compares them with a programmed expected rate. While the initiator gets less than its budget, the block asks for the programmed high pressure. Once the initiator has run ahead of its budget by a programmed byte allowance, the block drops to the programmed low pressure. The urgency therefore follows the initiator's measured service and is not a fixed priority.

Measurement uses a leaky credit accumulator in fixed point. On each cycle the bytes of a valid beat are added, scaled by 2^FRAC_W. The programmed rate is subtracted, in units of 1/2^FRAC_W byte per cycle. With the default FRAC_W of 5 and a 500 MHz clock, one rate unit is 15.625 MB/s, so a rate of 64 means 2 bytes per cycle, or 1000 MB/s. The integer part of the accumulator is the excess in bytes, and it is compared with the watermark. Software programs the rate, the watermark and the two pressure levels, then writes the flush command to start from a clean history.

Top module: `bw_pressure_regulator`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released with no traffic, `pressure` is 3 (high). The reset values are rate 0, watermark all ones, low level 0 and high level 3.
- R2: `pressure` never carries the value 2.
- R3: On each clock edge the credit becomes credit + (beat_vld ? beat_bytes*2^FRAC_W : 0) - rate. `pressure` changes on that same edge: it takes the low level when the new credit divided by 2^FRAC_W (rounded down) is at least the watermark, and the high level otherwise.
- R4: When the subtraction would go below zero, the credit stays at zero.
- R5: The credit saturates at its maximum, 2^(WM_W+FRAC_W+1)-1, and does not wrap.
- R6: A write with wr_sel=2 sets the low level from wr_data[1:0] and the high level from wr_data[3:2]. A value of 2 in either field is stored as 3.
- R7: A write with wr_sel=3 and wr_data[0]=1 clears the credit to zero and sets `pressure` to the high level on the next edge, whatever the watermark.
- R8: beat_bytes has no effect while beat_vld is 0.
- R9: A write with wr_sel=0 sets the rate from wr_data[RATE_W-1:0], and a write with wr_sel=1 sets the watermark from wr_data[WM_W-1:0]. A new rate, watermark or level value is first used on the edge after the write.
- R10: The rate is applied in units of 1/2^FRAC_W byte per cycle. A rate of 64 drains 2 bytes of excess per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_vld | input | 1 | A transfer beat completes this cycle |
| beat_bytes | input | BYTES_W | Bytes moved by the beat |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 rate, 1 watermark, 2 levels, 3 flush |
| wr_data | input | DATA_W | Write data |
| pressure | output | 2 | Urgency level sent to the interconnect |

## Verification
The hardest condition to reach from the ports is the top saturation of the credit. It takes hundreds of cycles of maximum-size beats with the rate set to zero. Its only visible effect is that pressure returns to high later than it would if the credit had wrapped. The stimulus pumps 255-byte beats for 600 cycles. It then sets a large rate and follows the drain cycle by cycle against the reference model, so the exact cycle on which pressure returns to high shows whether the credit was clipped. The zero floor is reached the same way, by idling under a large rate. In that case a wrapped credit would show up at once as a wrong low pressure.

// File: rtl/bwpr_pkg.sv
package bwpr_pkg;

    typedef enum logic [1:0] {
        SEL_RATE   = 2'd0,
        SEL_WMARK  = 2'd1,
        SEL_LEVELS = 2'd2,
        SEL_FLUSH  = 2'd3
    } bwpr_sel_e;

    localparam logic [1:0] PRESS_LOW  = 2'd0;
    localparam logic [1:0] PRESS_MED  = 2'd1;
    localparam logic [1:0] PRESS_BAD  = 2'd2;
    localparam logic [1:0] PRESS_HIGH = 2'd3;

    // Map the forbidden code onto the highest urgency
    function automatic logic [1:0] legal_press(input logic [1:0] code);
        return (code == PRESS_BAD) ? PRESS_HIGH : code;
    endfunction

endpackage

// File: rtl/bwpr_cfg_regs.sv
module bwpr_cfg_regs
    import bwpr_pkg::*;
#(
    parameter int RATE_W = 12,
    parameter int WM_W   = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [RATE_W-1:0] rate_q,
    output logic [WM_W-1:0]   wmark_q,
    output logic [1:0]        lvl_low_q,
    output logic [1:0]        lvl_high_q,
    output logic              flush
);

    localparam int NUM_LVL = 2;

    typedef struct packed {
        logic [RATE_W-1:0]           rate;
        logic [WM_W-1:0]             wmark;
        logic [NUM_LVL-1:0][1:0]     lvl;   // [0] low, [1] high
    } cfg_t;

    cfg_t st_d, st_q;
    logic [NUM_LVL-1:0][1:0] lvl_in;
    bwpr_sel_e sel;

    assign sel = bwpr_sel_e'(wr_sel);

    // Each level field is legalized on its way in (R6)
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign lvl_in[g] = legal_press(wr_data[2*g+1:2*g]);
    end

    always_comb begin
        st_d  = st_q;
        flush = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_RATE:   st_d.rate  = wr_data[RATE_W-1:0];
                SEL_WMARK:  st_d.wmark = wr_data[WM_W-1:0];
                SEL_LEVELS: st_d.lvl   = lvl_in;
                SEL_FLUSH:  flush      = wr_data[0];
                default:    st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rate   <= '0;
            st_q.wmark  <= '1;
            st_q.lvl[0] <= PRESS_LOW;
            st_q.lvl[1] <= PRESS_HIGH;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_q     = st_q.rate;
    assign wmark_q    = st_q.wmark;
    assign lvl_low_q  = st_q.lvl[0];
    assign lvl_high_q = st_q.lvl[1];

endmodule

// File: rtl/bwpr_credit_acc.sv
module bwpr_credit_acc #(
    parameter int BYTES_W = 8,
    parameter int RATE_W  = 12,
    parameter int FRAC_W  = 5,
    parameter int ACC_W   = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat_vld,
    input  logic [BYTES_W-1:0] beat_bytes,
    input  logic [RATE_W-1:0]  rate,
    input  logic               flush,
    output logic [ACC_W-1:0]   acc_nxt,
    output logic [ACC_W-1:0]   acc_q
);

    localparam int SUM_W = ACC_W + 1;
    localparam int SCL_W = BYTES_W + FRAC_W;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    typedef struct packed {
        logic [ACC_W-1:0] credit;
    } acc_t;

    acc_t st_d, st_q;
    logic [SUM_W-1:0] scaled, gross, drain, net;

    always_comb begin
        st_d   = st_q;
        scaled = beat_vld ? SUM_W'({beat_bytes, {FRAC_W{1'b0}}}) : '0;
        gross  = {1'b0, st_q.credit} + scaled;
        drain  = SUM_W'(rate);
        net    = gross - drain;
        if (flush) begin
            st_d.credit = '0;
        end else if (gross < drain) begin
            st_d.credit = '0;                       // floor
        end else if (net > {1'b0, ACC_MAX}) begin
            st_d.credit = ACC_MAX;                  // ceiling
        end else begin
            st_d.credit = net[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_nxt = st_d.credit;
    assign acc_q   = st_q.credit;

    logic unused_scl;
    assign unused_scl = ^SCL_W;

endmodule

// File: rtl/bwpr_press_sel.sv
module bwpr_press_sel
    import bwpr_pkg::*;
#(
    parameter int ACC_W  = 22,
    parameter int FRAC_W = 5,
    parameter int WM_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_nxt,
    input  logic [WM_W-1:0]  wmark,
    input  logic [1:0]       lvl_low,
    input  logic [1:0]       lvl_high,
    input  logic             flush,
    output logic [1:0]       pressure
);

    localparam int INT_W = ACC_W - FRAC_W;

    typedef struct packed {
        logic [1:0] level;
    } prs_t;

    prs_t st_d, st_q;
    logic [INT_W-1:0] excess;
    logic             over;

    always_comb begin
        excess = acc_nxt[ACC_W-1:FRAC_W];
        over   = (excess >= INT_W'(wmark));
        st_d   = st_q;
        if (flush)     st_d.level = lvl_high;
        else if (over) st_d.level = lvl_low;
        else           st_d.level = lvl_high;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.level <= PRESS_HIGH;
        else        st_q       <= st_d;
    end

    assign pressure = st_q.level;

endmodule

// File: rtl/bw_pressure_regulator.sv
module bw_pressure_regulator #(
    parameter int BYTES_W = 8,
    parameter int RATE_W  = 12,
    parameter int WM_W    = 16,
    parameter int FRAC_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat_vld,
    input  logic [BYTES_W-1:0] beat_bytes,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [1:0]         pressure
);

    localparam int ACC_W = WM_W + FRAC_W + 1;

    logic [RATE_W-1:0] rate_q;
    logic [WM_W-1:0]   wmark_q;
    logic [1:0]        lvl_low_q;
    logic [1:0]        lvl_high_q;
    logic              flush;
    logic [ACC_W-1:0]  acc_nxt;
    logic [ACC_W-1:0]  acc_q;

    bwpr_cfg_regs #(
        .RATE_W (RATE_W),
        .WM_W   (WM_W),
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rate_q     (rate_q),
        .wmark_q    (wmark_q),
        .lvl_low_q  (lvl_low_q),
        .lvl_high_q (lvl_high_q),
        .flush      (flush)
    );

    bwpr_credit_acc #(
        .BYTES_W (BYTES_W),
        .RATE_W  (RATE_W),
        .FRAC_W  (FRAC_W),
        .ACC_W   (ACC_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_vld   (beat_vld),
        .beat_bytes (beat_bytes),
        .rate       (rate_q),
        .flush      (flush),
        .acc_nxt    (acc_nxt),
        .acc_q      (acc_q)
    );

    bwpr_press_sel #(
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W),
        .WM_W   (WM_W)
    ) u_prs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_nxt  (acc_nxt),
        .wmark    (wmark_q),
        .lvl_low  (lvl_low_q),
        .lvl_high (lvl_high_q),
        .flush    (flush),
        .pressure (pressure)
    );

endmodule

// File: rtl/bwpr_checker.sv
module bwpr_checker #(
    parameter int ACC_W  = 22,
    parameter int FRAC_W = 5,
    parameter int WM_W   = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              beat_vld,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        pressure,
    input logic [ACC_W-1:0]  acc,
    input logic [WM_W-1:0]   wmark,
    input logic [1:0]        lvl_low,
    input logic [1:0]        lvl_high
);

    localparam int INT_W = ACC_W - FRAC_W;

    logic flush_req;
    assign flush_req = wr_en && (wr_sel == 2'd3) && wr_data[0];

    a_r2_never_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        pressure != 2'd2);

    a_r6_levels_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_low != 2'd2) && (lvl_high != 2'd2));

    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (acc == '0) && (pressure == $past(lvl_high)));

    a_r8_idle_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_vld && !flush_req) |=> (acc <= $past(acc)));

    a_r3_level_tracks_credit: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_req |=> ((acc[ACC_W-1:FRAC_W] >= INT_W'($past(wmark)))
                        ? (pressure == $past(lvl_low))
                        : (pressure == $past(lvl_high))));

endmodule

bind bw_pressure_regulator bwpr_checker #(
    .ACC_W  (ACC_W),
    .FRAC_W (FRAC_W),
    .WM_W   (WM_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_vld (beat_vld),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .pressure (pressure),
    .acc      (acc_q),
    .wmark    (wmark_q),
    .lvl_low  (lvl_low_q),
    .lvl_high (lvl_high_q)
);

// File: tb/tb_bw_pressure_regulator.sv
module tb_bw_pressure_regulator;

    localparam int CLK_PERIOD = 10;
    localparam int FRAC       = 5;
    localparam int ACC_MAX    = (1 << 22) - 1;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        beat_vld;
    logic [7:0]  beat_bytes;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [1:0]  pressure;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_acc, m_rate, m_wm, m_lo, m_hi, m_press;

    bw_pressure_regulator dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_vld   (beat_vld),
        .beat_bytes (beat_bytes),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .pressure   (pressure)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int legal(input int c);
        return (c == 2) ? 3 : c;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s pressure=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input int b, input bit we, input int sel,
                        input int d, input string tag);
        bit clr;
        int s;
        beat_vld   = v;
        beat_bytes = b[7:0];
        wr_en      = we;
        wr_sel     = sel[1:0];
        wr_data    = d[15:0];
        @(posedge clk);
        clr = we && (sel == 3) && d[0];
        if (clr) begin
            m_acc   = 0;
            m_press = m_hi;
        end else begin
            s = m_acc + (v ? b * (1 << FRAC) : 0);
            if (s < m_rate) s = 0;
            else s = s - m_rate;
            if (s > ACC_MAX) s = ACC_MAX;
            m_acc   = s;
            m_press = ((m_acc >> FRAC) >= m_wm) ? m_lo : m_hi;
        end
        if (we) begin
            case (sel)
                0: m_rate = d & 32'hFFF;
                1: m_wm   = d & 32'hFFFF;
                2: begin m_lo = legal(d & 3); m_hi = legal((d >> 2) & 3); end
                default: ;
            endcase
        end
        @(negedge clk);
        check(tag, int'(pressure), m_press);
        if (pressure == 2'd2) check("R2", int'(pressure), 3);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
    endtask

    task automatic beats(input int n, input int b, input string tag);
        for (int i = 0; i < n; i++) step(1, b, 0, 0, 0, tag);
    endtask

    task automatic wr(input int sel, input int d, input string tag);
        step(0, 0, 1, sel, d, tag);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < WDOG_LIMIT; i++) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog pressure=%0d expected=%0d", pressure, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; beat_vld = 0; beat_bytes = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        m_acc = 0; m_rate = 0; m_wm = 65535; m_lo = 0; m_hi = 3; m_press = 3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", int'(pressure), 3);
        rst_n = 1'b1;
        idle(2, "R1 after reset");

        // R6: levels, high written as 2 -> 3, low 1
        wr(2, 9, "R6 levels");
        wr(0, 64, "R9 rate");
        wr(1, 100, "R9 wmark");
        // R3: net +8 bytes per cycle crosses 100
        beats(20, 10, "R3 build");
        // R10: drains 2 bytes per cycle
        idle(60, "R10 drain");
        beats(14, 10, "R3 rebuild");
        // R8: bytes without valid must not move the credit
        for (int i = 0; i < 10; i++) step(0, 255, 0, 0, 0, "R8 no valid");
        // R7: flush while low, then watermark 0 case
        beats(10, 10, "R3 low again");
        wr(3, 1, "R7 flush");
        wr(3, 0, "R7 flush data0=0 ignored");
        wr(1, 0, "R9 wmark zero");
        wr(3, 1, "R7 flush wm zero");
        idle(2, "R7 after flush");
        wr(1, 100, "R9 wmark back");

        // R4: large rate floors credit at zero
        wr(0, 4095, "R4 rate big");
        idle(20, "R4 floor");
        step(1, 255, 0, 0, 0, "R4 beat after floor");
        idle(5, "R4 floor again");

        // R6: low written as 2 -> 3, high 1
        wr(2, 6, "R6 low coerced");
        beats(5, 255, "R6 low level output");
        idle(5, "R6 high level output");
        wr(2, 12, "R6 restore");

        // R5: saturate credit then drain
        wr(0, 0, "R5 rate zero");
        wr(1, 65535, "R5 wmark max");
        beats(600, 255, "R5 pump");
        wr(0, 4095, "R5 rate drain");
        idle(560, "R5 drain");

        // R9: watermark change mid-activity takes effect next edge
        wr(0, 64, "R9 rate");
        wr(1, 1000, "R9 wmark");
        beats(40, 20, "R9 build");
        wr(1, 200, "R9 wmark lower");
        beats(3, 20, "R9 after change");
        idle(10, "R3 tail");

        finish_run();
    end

endmodule